// File: doc/BRIEF.md
# Sequenced Register Command Processor

This block executes register commands that reach it as pre-parsed records. Each record holds a control word, a data word, a flag that says whether the command is timed, and a 64-bit timestamp. The control word chooses a 32-bit register write or a register read, names an 8-bit word address, and carries a 16-bit sequence number. Every record accepted at the input goes into an internal queue. Commands leave the queue strictly in arrival order, at most one per cycle.

A command executes when it reaches the head of the queue. If it is timed, it also waits until the externally supplied tick count `time_now` is at or past its timestamp. A write drives a one-cycle strobe on the register write port. A read takes its value combinationally from a readback mux that the surrounding logic supplies through `rd_addr` and `rd_data`. Every executed command produces one acknowledgement record of two words. The first word echoes the control word, so the sequence number sits in bits [31:16]. The second word carries the read value for a read and zero for a write.

The peer keeps up to 63 commands in flight before it waits for acknowledgements. The queue is sized to hold that many commands without loss. The block lowers `cmd_ready` only when the queue is completely full.

Top module: `seq_cmd_engine`

## Requirements
- R1: Control bits [7:0] are the word address. A write presents them on `wr_addr`. The head command's bits [7:0] appear on `rd_addr`.
- R2: Control bit 8 = 1 selects a write. The write raises `wr_stb` for exactly one cycle with `wr_data` equal to the data word. Bit 8 = 0 selects a read, which never raises `wr_stb`.
- R3: Each executed command raises `ack_valid` for one cycle. `ack_word0` equals the command's control word, so its sequence number (control bits [31:16]) appears in `ack_word0[31:16]`.
- R4: `ack_word1` is the value of `rd_data` for the read's address. For a write, `ack_word1` is 0.
- R5: The queue holds DEPTH = 64 commands. `cmd_ready` is low exactly when 64 commands are held. A record offered while `cmd_ready` is low is dropped.
- R6: A timed command (`cmd_timed` = 1) at the head executes only in a cycle where the unsigned value `time_now` >= its timestamp. A timestamp already in the past executes without delay.
- R7: An untimed command executes in the first cycle it is at the head. A record accepted at clock edge k produces its write strobe and ack after edge k+1 when the queue ahead of it is empty.
- R8: Commands execute and are acknowledged in arrival order, one ack per accepted command. A waiting timed head holds back every command behind it.
- R9: After reset `wr_stb` and `ack_valid` are low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 64 | Free-running tick count |
| cmd_valid | input | 1 | Command record offered |
| cmd_ready | output | 1 | Queue has room |
| cmd_ctrl | input | 32 | Control word: seq [31:16], write flag [8], address [7:0] |
| cmd_data | input | 32 | Data word |
| cmd_timed | input | 1 | Command carries a timestamp |
| cmd_time | input | 64 | Timestamp in ticks |
| wr_stb | output | 1 | Register write strobe |
| wr_addr | output | 8 | Write word address |
| wr_data | output | 32 | Write data |
| rd_addr | output | 8 | Readback mux select (head command's address) |
| rd_data | input | 32 | Readback mux value |
| ack_valid | output | 1 | Acknowledgement record valid |
| ack_word0 | output | 32 | Echoed control word |
| ack_word1 | output | 32 | Read value, or 0 for a write |

## Verification
A record accepted at edge k whose path ahead is clear yields its write strobe and ack after edge k+1. A timed head yields them after the first edge at which `time_now` has reached its stamp. `cmd_ready` reflects the queue occupancy after each edge. The bench runs a behavioural queue model at each rising edge using the same sampled inputs and time. It compares every output at the following falling edge, so each expected value is due exactly one register stage after the edge that produced it.

// File: rtl/seq_cmd_engine.sv
module seq_cmd_engine #(
  parameter int DEPTH = 64,
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int TW    = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] time_now,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [DW-1:0] cmd_ctrl,
  input  logic [DW-1:0] cmd_data,
  input  logic          cmd_timed,
  input  logic [TW-1:0] cmd_time,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          ack_valid,
  output logic [DW-1:0] ack_word0,
  output logic [DW-1:0] ack_word1
);
  localparam int PW = $clog2(DEPTH);
  localparam int WR_BIT = AW;

  logic [DW-1:0] ctrl_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [TW-1:0] time_q [DEPTH];
  logic          timed_q [DEPTH];

  logic [PW:0]   wptr, rptr, occ;
  logic [PW-1:0] hd;
  logic [DW-1:0] hd_ctrl;
  logic          hd_timed, due, go, push;
  logic [TW-1:0] hd_time;

  assign occ       = wptr - rptr;
  assign hd        = rptr[PW-1:0];
  assign hd_ctrl   = ctrl_q[hd];
  assign hd_timed  = timed_q[hd];
  assign hd_time   = time_q[hd];
  assign cmd_ready = occ != (PW+1)'(DEPTH);
  assign push      = cmd_valid && cmd_ready;
  assign due       = !hd_timed || (time_now >= hd_time);
  assign go        = (occ != '0) && due;
  assign rd_addr   = hd_ctrl[AW-1:0];

  always_ff @(posedge clk) begin
    if (push) begin
      ctrl_q[wptr[PW-1:0]]  <= cmd_ctrl;
      data_q[wptr[PW-1:0]]  <= cmd_data;
      time_q[wptr[PW-1:0]]  <= cmd_time;
      timed_q[wptr[PW-1:0]] <= cmd_timed;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      wr_stb    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      ack_valid <= 1'b0;
      ack_word0 <= '0;
      ack_word1 <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (go)   rptr <= rptr + 1'b1;
      wr_stb    <= go && hd_ctrl[WR_BIT];
      ack_valid <= go;
      if (go) begin
        wr_addr   <= hd_ctrl[AW-1:0];
        wr_data   <= data_q[hd];
        ack_word0 <= hd_ctrl;
        ack_word1 <= hd_ctrl[WR_BIT] ? '0 : rd_data;
      end
    end
  end
endmodule

module seq_cmd_engine_chk #(
  parameter int DEPTH = 64,
  parameter int AW    = 8,
  parameter int DW    = 32,
  parameter int TW    = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic [TW-1:0] time_now,
  input logic          cmd_ready,
  input logic          wr_stb,
  input logic [AW-1:0] wr_addr,
  input logic          ack_valid,
  input logic [DW-1:0] ack_word0,
  input logic [DW-1:0] ack_word1,
  input logic [$clog2(DEPTH):0] occ,
  input logic          hd_timed,
  input logic [TW-1:0] hd_time
);
  a_r2_stb_means_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (ack_valid && ack_word0[AW]));
  a_r2_write_strobe_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_word0[AW]) |-> wr_stb);
  a_r1_addr_from_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_addr == ack_word0[AW-1:0]));
  a_r4_write_ack_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_word0[AW]) |-> (ack_word1 == '0));
  a_r6_time_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (!$past(hd_timed) || ($past(time_now) >= $past(hd_time))));
  a_r8_ack_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> ($past(occ) != '0));
  a_r5_ready_full: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |-> (occ == ($clog2(DEPTH)+1)'(DEPTH)));
endmodule

bind seq_cmd_engine seq_cmd_engine_chk #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .time_now(time_now), .cmd_ready(cmd_ready),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .ack_valid(ack_valid),
  .ack_word0(ack_word0), .ack_word1(ack_word1), .occ(occ),
  .hd_timed(hd_timed), .hd_time(hd_time)
);

// File: tb/tb_seq_cmd_engine.sv
module tb_seq_cmd_engine;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] time_now = 64'd0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_ctrl = '0, cmd_data = '0;
  logic        cmd_timed = 1'b0;
  logic [63:0] cmd_time = '0;
  logic        wr_stb, ack_valid;
  logic [7:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data, ack_word0, ack_word1;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] rbv(input logic [7:0] a);
    return {a ^ 8'hC3, 8'h5A, ~a, a};
  endfunction
  assign rd_data = rbv(rd_addr);

  seq_cmd_engine dut (
    .clk(clk), .rst_n(rst_n), .time_now(time_now),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_ctrl(cmd_ctrl),
    .cmd_data(cmd_data), .cmd_timed(cmd_timed), .cmd_time(cmd_time),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ack_valid(ack_valid),
    .ack_word0(ack_word0), .ack_word1(ack_word1)
  );

  logic [31:0] q_ctrl[$], q_data[$];
  logic [63:0] q_ts[$];
  bit          q_timed[$];
  bit          e_stb = 0, e_ack = 0, e_rdy = 1;
  logic [7:0]  e_addr = '0;
  logic [31:0] e_data = '0, e_w0 = '0, e_w1 = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q_ctrl.delete(); q_data.delete(); q_ts.delete(); q_timed.delete();
      e_stb = 0; e_ack = 0; e_rdy = 1;
    end else begin
      bit full;
      full = (q_ctrl.size() == DEPTH);
      e_stb = 0; e_ack = 0;
      if (q_ctrl.size() > 0 && (!q_timed[0] || time_now >= q_ts[0])) begin
        logic [31:0] c, d;
        c = q_ctrl.pop_front(); d = q_data.pop_front();
        void'(q_ts.pop_front()); void'(q_timed.pop_front());
        e_ack = 1; e_w0 = c;
        e_w1 = c[8] ? 32'd0 : rbv(c[7:0]);
        e_stb = c[8]; e_addr = c[7:0]; e_data = d;
      end
      if (cmd_valid && !full) begin
        q_ctrl.push_back(cmd_ctrl); q_data.push_back(cmd_data);
        q_ts.push_back(cmd_time); q_timed.push_back(cmd_timed);
      end
      e_rdy = (q_ctrl.size() != DEPTH);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk(cmd_ready == e_rdy, "R5 R9 cmd_ready", 64'(cmd_ready), 64'(e_rdy));
      chk(wr_stb == e_stb, "R2 R9 wr_stb", 64'(wr_stb), 64'(e_stb));
      chk(ack_valid == e_ack, "R3 R6 R7 R8 ack_valid", 64'(ack_valid), 64'(e_ack));
      if (e_stb) begin
        chk(wr_addr == e_addr, "R1 wr_addr", 64'(wr_addr), 64'(e_addr));
        chk(wr_data == e_data, "R2 wr_data", 64'(wr_data), 64'(e_data));
      end
      if (e_ack) begin
        chk(ack_word0 == e_w0, "R3 ack_word0", 64'(ack_word0), 64'(e_w0));
        chk(ack_word1 == e_w1, "R4 ack_word1", 64'(ack_word1), 64'(e_w1));
      end
      time_now <= time_now + 64'd1;
    end
  end

  function automatic logic [31:0] mk(input int seq, input bit wr, input logic [7:0] a);
    return {16'(seq), 7'd0, wr, a};
  endfunction

  task automatic drive(input bit v, input logic [31:0] c, input logic [31:0] d,
                       input bit t, input logic [63:0] ts);
    @(negedge clk);
    cmd_valid = v; cmd_ctrl = c; cmd_data = d; cmd_timed = t; cmd_time = ts;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, '0, '0, 0, '0);
  endtask

  initial begin
    int s;
    s = 1;
    repeat (4) @(negedge clk);          // R9 reset state compared each cycle
    rst_n = 1'b1;
    idle(2);
    // R1 R2 R3 R4 R7: untimed mix, back to back
    for (int i = 0; i < 12; i++) begin
      drive(1, mk(s, i % 3 != 0, 8'(i * 21 + 3)), 32'hA5000000 + 32'(i * 77), 0, 64'd0);
      s++;
    end
    idle(4);
    // R6 R8: timed head in the future holds later untimed commands
    drive(1, mk(s, 1, 8'h10), 32'h1111_0000, 1, time_now + 64'd20); s++;
    drive(1, mk(s, 0, 8'h22), 32'h0, 0, 64'd0); s++;
    drive(1, mk(s, 1, 8'hFF), 32'hDEAD_BEEF, 0, 64'd0); s++;
    idle(30);
    // R6: late timestamp executes at once
    drive(1, mk(s, 0, 8'h7E), 32'h0, 1, 64'd5); s++;
    drive(1, mk(s, 1, 8'h00), 32'h1234_5678, 1, time_now); s++;
    idle(4);
    // R5 R8: fill behind a waiting timed head, overflow dropped
    drive(1, mk(s, 1, 8'h33), 32'h3333_3333, 1, time_now + 64'd200); s++;
    for (int i = 0; i < 70; i++) begin
      drive(1, mk(s, i[0], 8'(i)), 32'(i) ^ 32'hC0DE_0000, 0, 64'd0);
      s++;
    end
    idle(300);
    // R7: single command into an empty queue, 0xFFFF sequence
    drive(1, mk(16'hFFFF, 0, 8'h81), 32'h0, 0, 64'd0);
    idle(5);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule